// File: doc/BRIEF.md
# Read Data Fanout Tree

This block carries read beats coming back from one memory PHY to the write side of the read FIFOs of up to eight ports. A beat on the PHY side consists of a push strobe, a one-hot port select, a FIFO write address, a data word and the word address of that beat inside its cacheline. Each port receives its own copy of the push strobe, FIFO address, word address and data. The block delivers each beat to the single port that the select names, with a fixed number of cycles of latency.

Burst data comes back in sequential word order, but the requested target word is not always the first beat. For this reason the word address is carried alongside every beat, so that the consuming port can tell which word it is writing.

The `FANOUT` parameter sets how many ports a single pipeline register copy feeds:

| `FANOUT` | Register copies (8 ports) | Ports per copy |
|---|---|---|
| 0 | none | the PHY bundle goes straight to every port |
| 1 | eight | 1 |
| 2 | four | 2 |
| 4 | two | 4 |
| 8 | one | all ports |

Copy `c` serves ports `c*FANOUT` up to `c*FANOUT+FANOUT-1`. Any other value of `FANOUT` stops elaboration.

`IN_PIPE` adds one register stage in front of the fanout for the whole input bundle. This setting is shared by all ports.

The streams have no back-pressure. The push strobe acts as a valid that cannot be refused, and the FIFOs behind the block are sized so that they always accept a beat.

Top module: `rd_fanout_tree`

## Requirements
- R1: With `FANOUT`=0 and `IN_PIPE`=0 there is no register stage, and a beat appears at its port in the same cycle it is presented.
- R2: The latency from the PHY input to the port output is `IN_PIPE` (0 or 1) plus one when `FANOUT` is nonzero, counted in clock cycles.
- R3: The port select is one-hot, with bit p naming port p. A push reaches only port p, and no other port sees a push in that cycle.
- R4: The FIFO address and data word of a beat appear unchanged on the selected port in the same cycle as that port's push.
- R5: The word address of each beat reaches the port unchanged and aligned with its push, whatever the order of the beats. Wrapped bursts in which the target word is not first are included.
- R6: While synchronous active-high reset is asserted, every registered variant drives all port push outputs low, even if the PHY presents pushes.
- R7: Each legal `FANOUT` value (0, 1, 2, 4, 8) gives the same per-port delivery. Copy c serves ports c*`FANOUT` through c*`FANOUT`+`FANOUT`-1. Any other value stops elaboration.
- R8: A new beat can be accepted on every cycle, with no bubbles, and each beat is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_push | input | 1 | Beat valid from the PHY |
| phy_port_sel | input | NUM_PORTS | One-hot destination port |
| phy_fifo_addr | input | ADDR_W | FIFO write address |
| phy_word_addr | input | WORD_AW | Word address of the beat in its cacheline |
| phy_data | input | DATA_W | Read data word |
| port_push | output | NUM_PORTS | Per-port FIFO push |
| port_fifo_addr | output | NUM_PORTS*ADDR_W | Per-port FIFO address, port p at bits p*ADDR_W upward |
| port_word_addr | output | NUM_PORTS*WORD_AW | Per-port word address, port p at bits p*WORD_AW upward |
| port_data | output | NUM_PORTS*DATA_W | Per-port data, port p at bits p*DATA_W upward |

## Verification
The assertions assume that the port select is one-hot whenever a push is presented. They also assume that the input bundle carries real beats only once reset has been released.

The stimulus follows these rules:
- Idle cycles drive an all-zero select.
- Every push carries a single randomly chosen select bit.
- During reset, pushes are presented only to show that registered variants suppress them. They are dropped before reset is released.

Six instances with different `FANOUT` and `IN_PIPE` settings receive the same stimulus. Each one is checked against its own expected latency.

// File: rtl/rdft_pkg.sv
package rdft_pkg;

  // Legal ports-per-copy settings; zero means no fanout register.
  function automatic bit fanout_ok(input int f);
    return (f == 0) || (f == 1) || (f == 2) || (f == 4) || (f == 8);
  endfunction

  // Number of register copies needed to cover np ports.
  function automatic int copy_count(input int np, input int f);
    if (f == 0) return 0;
    return (np + f - 1) / f;
  endfunction

  // Cycles from PHY input to port output.
  function automatic int total_latency(input int in_pipe, input int f);
    return in_pipe + ((f != 0) ? 1 : 0);
  endfunction

endpackage

// File: rtl/rdft_in_stage.sv
module rdft_in_stage #(
  parameter int NUM_PORTS = 8,
  parameter int BITS_W    = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_push,
  input  logic [NUM_PORTS-1:0] in_sel,
  input  logic [BITS_W-1:0]    in_bits,
  output logic                 out_push,
  output logic [NUM_PORTS-1:0] out_sel,
  output logic [BITS_W-1:0]    out_bits
);

  always_ff @(posedge clk) begin
    if (rst) out_push <= 1'b0;
    else     out_push <= in_push;
  end

  always_ff @(posedge clk) begin
    out_sel  <= in_sel;
    out_bits <= in_bits;
  end

  // R2: a registered push is exactly the input push one cycle earlier
  assert_in_stage_delay_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_push == $past(in_push)));

endmodule

// File: rtl/rdft_copy.sv
module rdft_copy #(
  parameter int NSERVE = 1,
  parameter int BITS_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_push,
  input  logic [NSERVE-1:0] in_sel,
  input  logic [BITS_W-1:0] in_bits,
  output logic [NSERVE-1:0] out_push,
  output logic [BITS_W-1:0] out_bits
);

  // Per-port push strobes are reset; the payload copy is not.
  always_ff @(posedge clk) begin
    if (rst)          out_push <= '0;
    else if (in_push) out_push <= in_sel;
    else              out_push <= '0;
  end

  always_ff @(posedge clk) begin
    out_bits <= in_bits;
  end

  // R3: a copy never pushes more than one of its ports at once
  assert_copy_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_push));

endmodule

// File: rtl/rd_fanout_tree.sv
module rd_fanout_tree #(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int WORD_AW   = 3,
  parameter int FANOUT    = 8,
  parameter int IN_PIPE   = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           phy_push,
  input  logic [NUM_PORTS-1:0]           phy_port_sel,
  input  logic [ADDR_W-1:0]              phy_fifo_addr,
  input  logic [WORD_AW-1:0]             phy_word_addr,
  input  logic [DATA_W-1:0]              phy_data,
  output logic [NUM_PORTS-1:0]           port_push,
  output logic [NUM_PORTS*ADDR_W-1:0]    port_fifo_addr,
  output logic [NUM_PORTS*WORD_AW-1:0]   port_word_addr,
  output logic [NUM_PORTS*DATA_W-1:0]    port_data
);

  localparam int BITS_W = ADDR_W + WORD_AW + DATA_W;
  localparam int NCOPY  = rdft_pkg::copy_count(NUM_PORTS, FANOUT);
  localparam int LAT    = rdft_pkg::total_latency(IN_PIPE, FANOUT);

  // R7: reject illegal settings at elaboration
  if (!rdft_pkg::fanout_ok(FANOUT)) begin : g_bad_fanout
    $error("rd_fanout_tree: FANOUT must be 0, 1, 2, 4 or 8");
  end
  if (NUM_PORTS < 1 || NUM_PORTS > 8) begin : g_bad_ports
    $error("rd_fanout_tree: NUM_PORTS must be 1 to 8");
  end
  if (IN_PIPE != 0 && IN_PIPE != 1) begin : g_bad_pipe
    $error("rd_fanout_tree: IN_PIPE must be 0 or 1");
  end

  // Bundle order: {fifo address, word address, data}
  logic [BITS_W-1:0]    raw_bits;
  logic                 s_push;
  logic [NUM_PORTS-1:0] s_sel;
  logic [BITS_W-1:0]    s_bits;

  assign raw_bits = {phy_fifo_addr, phy_word_addr, phy_data};

  if (IN_PIPE != 0) begin : g_in_reg
    rdft_in_stage #(.NUM_PORTS(NUM_PORTS), .BITS_W(BITS_W)) u_in (
      .clk      (clk),
      .rst      (rst),
      .in_push  (phy_push),
      .in_sel   (phy_port_sel),
      .in_bits  (raw_bits),
      .out_push (s_push),
      .out_sel  (s_sel),
      .out_bits (s_bits)
    );
  end else begin : g_in_wire
    assign s_push = phy_push;
    assign s_sel  = phy_port_sel;
    assign s_bits = raw_bits;
  end

  if (FANOUT == 0) begin : g_direct
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_push[p] = s_push & s_sel[p];
      assign port_fifo_addr[p*ADDR_W +: ADDR_W]    = s_bits[BITS_W-1 -: ADDR_W];
      assign port_word_addr[p*WORD_AW +: WORD_AW]  = s_bits[DATA_W +: WORD_AW];
      assign port_data[p*DATA_W +: DATA_W]         = s_bits[DATA_W-1:0];
    end
  end else begin : g_tree
    logic [BITS_W-1:0] copy_bits [NCOPY];

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      localparam int LO = c * FANOUT;
      localparam int N  = (NUM_PORTS - LO < FANOUT) ? (NUM_PORTS - LO) : FANOUT;
      rdft_copy #(.NSERVE(N), .BITS_W(BITS_W)) u_copy (
        .clk      (clk),
        .rst      (rst),
        .in_push  (s_push),
        .in_sel   (s_sel[LO +: N]),
        .in_bits  (s_bits),
        .out_push (port_push[LO +: N]),
        .out_bits (copy_bits[c])
      );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int C = p / FANOUT;
      assign port_fifo_addr[p*ADDR_W +: ADDR_W]   = copy_bits[C][BITS_W-1 -: ADDR_W];
      assign port_word_addr[p*WORD_AW +: WORD_AW] = copy_bits[C][DATA_W +: WORD_AW];
      assign port_data[p*DATA_W +: DATA_W]        = copy_bits[C][DATA_W-1:0];
    end
  end

  // R3: input rule, the select names exactly one port whenever a push is offered
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    phy_push |-> $onehot(phy_port_sel));

  // R3: at most one port is pushed in any cycle
  assert_port_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_push));

  if (LAT > 0) begin : g_timed_checks
    // R6: the cycle after reset is seen, all port pushes are low
    assert_clear_after_reset_R6: assert property (@(posedge clk)
      $past(rst) |-> (port_push == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      // R2: a port push matches a selected PHY push exactly LAT cycles earlier
      assert_push_latency_R2: assert property (@(posedge clk) disable iff (rst)
        port_push[p] |-> $past(phy_push && phy_port_sel[p], LAT));
      // R4: address and data travel with the push
      assert_payload_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        port_push[p] |-> (port_data[p*DATA_W +: DATA_W] == $past(phy_data, LAT) &&
                          port_fifo_addr[p*ADDR_W +: ADDR_W] == $past(phy_fifo_addr, LAT)));
      // R5: word address travels with the push
      assert_word_addr_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        port_push[p] |-> (port_word_addr[p*WORD_AW +: WORD_AW] == $past(phy_word_addr, LAT)));
    end
  end

endmodule

// File: tb/tb_rd_fanout_tree.sv
module tb_rd_fanout_tree;

  localparam int NP  = 8;
  localparam int DW  = 32;
  localparam int AW  = 5;
  localparam int WAW = 3;
  localparam int NI  = 6;
  localparam int FAN  [NI] = '{0, 1, 2, 4, 8, 8};
  localparam int PIPE [NI] = '{0, 1, 0, 1, 0, 1};

  typedef struct {
    int             due;
    int             port;
    logic [AW-1:0]  addr;
    logic [WAW-1:0] wd;
    logic [DW-1:0]  data;
  } item_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           phy_push = 1'b0;
  logic [NP-1:0]  phy_sel = '0;
  logic [AW-1:0]  phy_addr = '0;
  logic [WAW-1:0] phy_wd = '0;
  logic [DW-1:0]  phy_data = '0;

  logic [NP-1:0]     o_push [NI];
  logic [NP*AW-1:0]  o_addr [NI];
  logic [NP*WAW-1:0] o_wd   [NI];
  logic [NP*DW-1:0]  o_data [NI];

  item_t q [NI][$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit monitor_on = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar k = 0; k < NI; k++) begin : g_inst
    rd_fanout_tree #(.NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(AW), .WORD_AW(WAW),
                     .FANOUT(FAN[k]), .IN_PIPE(PIPE[k])) dut (
      .clk(clk), .rst(rst), .phy_push(phy_push), .phy_port_sel(phy_sel),
      .phy_fifo_addr(phy_addr), .phy_word_addr(phy_wd), .phy_data(phy_data),
      .port_push(o_push[k]), .port_fifo_addr(o_addr[k]),
      .port_word_addr(o_wd[k]), .port_data(o_data[k]));
  end

  function automatic int lat_of(input int k);
    return PIPE[k] + ((FAN[k] != 0) ? 1 : 0);
  endfunction

  // Driver: present one beat in this cycle and queue its expectation per instance
  task automatic drive_beat(input int port, input logic [AW-1:0] a,
                            input logic [WAW-1:0] w, input logic [DW-1:0] d);
    item_t it;
    @(posedge clk); #1;
    phy_push = 1'b1; phy_sel = '0; phy_sel[port] = 1'b1;
    phy_addr = a; phy_wd = w; phy_data = d;
    for (int k = 0; k < NI; k++) begin
      it.due = cyc + lat_of(k); it.port = port;
      it.addr = a; it.wd = w; it.data = d;
      q[k].push_back(it);
    end
  endtask

  task automatic drive_idle();
    @(posedge clk); #1;
    phy_push = 1'b0; phy_sel = '0;
    phy_addr = AW'($urandom); phy_wd = WAW'($urandom); phy_data = $urandom;
  endtask

  task automatic report(input string req, input int k, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    bad++;
    $display("FAIL %s inst=%0d (fanout=%0d pipe=%0d) %s cyc=%0d actual=%0h expected=%0h",
             req, k, FAN[k], PIPE[k], what, cyc, act, exp);
  endtask

  // Monitor: pop due items and compare outputs away from the clock edge
  always @(negedge clk) begin
    if (monitor_on && !rst) begin
      for (int k = 0; k < NI; k++) begin
        logic [NP-1:0] exp_push;
        item_t it;
        bit have;
        string req_t;
        exp_push = '0; have = 0;
        req_t = (k == 0) ? "R1" : "R2/R7";
        if (q[k].size() > 0 && q[k][0].due == cyc) begin
          it = q[k].pop_front();
          have = 1;
          exp_push[it.port] = 1'b1;
        end
        total++;
        if (o_push[k] !== exp_push) begin
          if (exp_push != '0) report(req_t, k, "push timing", 64'(o_push[k]), 64'(exp_push));
          else                report("R3", k, "stray push", 64'(o_push[k]), 64'(exp_push));
        end
        if (have) begin
          total++;
          if (o_addr[k][it.port*AW +: AW] !== it.addr)
            report("R4", k, "fifo addr", 64'(o_addr[k][it.port*AW +: AW]), 64'(it.addr));
          total++;
          if (o_data[k][it.port*DW +: DW] !== it.data)
            report("R4", k, "data", 64'(o_data[k][it.port*DW +: DW]), 64'(it.data));
          total++;
          if (o_wd[k][it.port*WAW +: WAW] !== it.wd)
            report("R5", k, "word addr", 64'(o_wd[k][it.port*WAW +: WAW]), 64'(it.wd));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    // R6: pushes offered during reset must not reach any registered output
    phy_push = 1'b1; phy_sel = 8'b0000_1000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      if (lat_of(k) > 0) begin
        total++;
        if (o_push[k] !== '0) report("R6", k, "push in reset", 64'(o_push[k]), 64'd0);
      end else begin
        // R1: with no register stage the push passes straight through
        total++;
        if (o_push[k] !== 8'b0000_1000) report("R1", k, "comb push", 64'(o_push[k]), 64'h8);
      end
    end
    @(posedge clk); #1; phy_push = 1'b0; phy_sel = '0;
    @(posedge clk); #1; rst = 1'b0;
    monitor_on = 1;
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      total++;
      if (o_push[k] !== '0) report("R6", k, "push after reset", 64'(o_push[k]), 64'd0);
    end

    // R3/R7: walk each port in turn, idle between beats
    for (int p = 0; p < NP; p++) begin
      drive_beat(p, AW'(p + 3), WAW'(p), 32'hA500_0000 | 32'(p));
      drive_idle();
      drive_idle();
    end

    // R5: wrapped cacheline bursts, target word not first
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 8; b++)
        drive_beat(5, AW'(b), WAW'(s * 3 + b), $urandom);
      drive_idle();
    end

    // R8: a beat every cycle to random ports
    for (int i = 0; i < 400; i++)
      drive_beat(int'($urandom_range(NP - 1)), AW'($urandom), WAW'($urandom), $urandom);

    // Sparse random traffic
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(2) == 0) drive_beat(int'($urandom_range(NP - 1)), AW'($urandom),
                                              WAW'($urandom), $urandom);
      else drive_idle();
    end

    repeat (6) drive_idle();
    @(negedge clk);
    // R8: every beat delivered exactly once, nothing left pending
    for (int k = 0; k < NI; k++) begin
      total++;
      if (q[k].size() != 0) report("R8", k, "undelivered beats", 64'(q[k].size()), 64'd0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule